// File: doc/BRIEF.md
# Programmable Sample Delay Line

This block delays a stream of fixed-width samples by a whole number of accepted samples, chosen at run time. Every clock it can take one sample, qualified by an input valid. Each accepted sample is written into a 1024-entry circular store. On the next clock edge the block presents the sample that was accepted a chosen number of samples earlier. There is never a stall, so the block fits inside a single-cycle-throughput pipeline.

A single read pointer steps by one for each accepted sample. The write address is that pointer plus the delay, reduced to ten bits by masking, so the read side never subtracts and no index can fall out of range. The output valid stays low until enough samples have been written under the current delay setting. Memory contents that were never written, or that were written under an older setting, are therefore never marked valid.

Top module: `sample_delay_line`

## Requirements
- R1: While reset is held, and on the first clock after it is released with no sample offered, `outValid` is low.
- R2: With a constant delay D, the first D samples accepted after reset, or after a delay change, produce `outValid` low. Every later accepted sample produces `outValid` high.
- R3: A sample accepted at a clock edge yields its output one edge later. When valid, `outData` equals the sample accepted exactly D accepted samples earlier. Back-to-back samples are accepted on every clock with no stall.
- R4: A delay input of 0 behaves exactly as a delay of 1.
- R5: The largest delay, 1023, is honoured. Delays hold correctly across more than 1024 accepted samples, with the pointers wrapping modulo 1024 by masking.
- R6: A clock with `inValid` low advances no pointer and does not count as a sample. It makes `outValid` low on the following clock.
- R7: A new delay value takes effect on the next accepted sample. That sample restarts the fill count of R2, so no sample already presented is presented again and stale memory is never marked valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Qualifies `inData` this cycle |
| inData | input | DATA_W | Sample to be delayed |
| delaySel | input | 10 | Delay in accepted samples; 0 is treated as 1 |
| outValid | output | 1 | `outData` holds a delayed sample |
| outData | output | DATA_W | Delayed sample |

## Verification
The bench targets the fill boundary, where a design with an off-by-one count marks the last stale entry valid or drops the first real one. It drives idle gaps between samples, which catch a design that advances its pointer or its fill count on cycles with no sample and so emits the wrong sample afterwards. A delay of 0 is applied to expose a design that writes and reads the same address and returns the current sample or stale data. A run of over a thousand samples at delay 1023 checks wrap-around, which a design with a wrongly sized mask or counter breaks by returning samples from the wrong lap. Delay changes in both directions catch a design that keeps the old fill count and flags stale entries as valid.

// File: rtl/sample_delay_pkg.sv
package sample_delay_pkg;

  // Ten-bit addressing gives the fixed 1024-entry store.
  localparam int ADDR_W = 10;
  localparam int DEPTH  = 1 << ADDR_W;

  // Strobes and addresses handed from control to datapath each cycle.
  typedef struct packed {
    logic              wrEn;
    logic              rdEn;
    logic              emit;
    logic [ADDR_W-1:0] wrAddr;
    logic [ADDR_W-1:0] rdAddr;
  } dlyStrobe_t;

endpackage

// File: rtl/sample_delay_ctrl.sv
module sample_delay_ctrl
  import sample_delay_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [ADDR_W-1:0] delaySel,
  output dlyStrobe_t        strb
);

  localparam logic [ADDR_W-1:0] CNT_MAX   = '1;
  localparam logic [ADDR_W:0]   ADDR_MASK = (ADDR_W+1)'(DEPTH - 1);

  logic [ADDR_W-1:0] rdPtr;
  logic [ADDR_W-1:0] fillCnt;
  logic [ADDR_W-1:0] lastDelay;
  logic [ADDR_W-1:0] effDelay;
  logic [ADDR_W-1:0] baseCnt;
  logic [ADDR_W:0]   wrSum;
  logic              delayChanged;

  // A zero request is clamped up to one so write never lands on the read slot.
  always_comb begin
    effDelay     = (delaySel == '0) ? ADDR_W'(1) : delaySel;
    delayChanged = (effDelay != lastDelay);
    baseCnt      = delayChanged ? '0 : fillCnt;
    wrSum        = ({1'b0, rdPtr} + {1'b0, effDelay}) & ADDR_MASK;
  end

  always_comb begin
    strb.wrEn   = inValid;
    strb.rdEn   = inValid;
    strb.emit   = inValid && (baseCnt >= effDelay);
    strb.rdAddr = rdPtr;
    strb.wrAddr = wrSum[ADDR_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdPtr     <= '0;
      fillCnt   <= '0;
      lastDelay <= '0;
    end else if (inValid) begin
      rdPtr     <= rdPtr + 1'b1;
      lastDelay <= effDelay;
      fillCnt   <= (baseCnt == CNT_MAX) ? CNT_MAX : baseCnt + 1'b1;
    end
  end

endmodule

// File: rtl/sample_delay_dpath.sv
module sample_delay_dpath
  import sample_delay_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] inData,
  input  dlyStrobe_t        strb,
  output logic              outValid,
  output logic [DATA_W-1:0] outData
);

  logic [DATA_W-1:0] store [DEPTH];
  logic [DATA_W-1:0] rdData;

  // One synchronous write port.
  always_ff @(posedge clk) begin
    if (strb.wrEn) store[strb.wrAddr] <= inData;
  end

  // One synchronous read port; its latency is the single output cycle.
  always_ff @(posedge clk) begin
    if (strb.rdEn) rdData <= store[strb.rdAddr];
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= strb.emit;
  end

  assign outData = rdData;

endmodule

// File: rtl/sample_delay_line.sv
module sample_delay_line
  import sample_delay_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  input  logic [ADDR_W-1:0] delaySel,
  output logic              outValid,
  output logic [DATA_W-1:0] outData
);

  dlyStrobe_t strb;

  sample_delay_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .delaySel (delaySel),
    .strb     (strb)
  );

  sample_delay_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk      (clk),
    .rst      (rst),
    .inData   (inData),
    .strb     (strb),
    .outValid (outValid),
    .outData  (outData)
  );

endmodule

// File: rtl/sample_delay_line_chk.sv
module sample_delay_line_chk
  import sample_delay_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic [ADDR_W-1:0] delaySel,
  input logic              outValid,
  input dlyStrobe_t        strb
);

  logic [ADDR_W-1:0] chkEff;
  logic [ADDR_W-1:0] chkLast;

  assign chkEff = (delaySel == '0) ? ADDR_W'(1) : delaySel;

  always_ff @(posedge clk) begin
    if (rst)          chkLast <= '0;
    else if (inValid) chkLast <= chkEff;
  end

  // R6: an idle cycle never yields a valid output.
  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);

  // R6: the read pointer holds across idle cycles.
  p_ptr_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> strb.rdAddr == $past(strb.rdAddr));

  // R3: the read pointer steps by one per accepted sample, wrapping at 1024.
  p_ptr_step_r3: assert property (@(posedge clk) disable iff (rst)
    inValid |=> strb.rdAddr == ADDR_W'($past(strb.rdAddr) + 1'b1));

  // R4: the write slot never coincides with the read slot.
  p_no_collide_r4: assert property (@(posedge clk) disable iff (rst)
    strb.wrEn |-> strb.wrAddr != strb.rdAddr);

  // R2: a valid output always follows an accepted sample.
  p_valid_from_input_r2: assert property (@(posedge clk) disable iff (rst)
    outValid |-> $past(inValid));

  // R7: a sample carrying a new delay restarts the fill, so its output is invalid.
  p_change_restarts_r7: assert property (@(posedge clk) disable iff (rst)
    (inValid && chkEff != chkLast) |=> !outValid);

endmodule

bind sample_delay_line sample_delay_line_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .inValid  (inValid),
  .delaySel (delaySel),
  .outValid (outValid),
  .strb     (strb)
);

// File: tb/sample_delay_line_tb.sv
module sample_delay_line_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DW         = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          inValid = 1'b0;
  logic [DW-1:0] inData = '0;
  logic [9:0]    delaySel = 10'd1;
  logic          outValid;
  logic [DW-1:0] outData;

  int testsRun  = 0;
  int testsFail = 0;

  logic          expV [$];
  logic [DW-1:0] expD [$];
  string         expTag [$];

  logic [DW-1:0] hist [0:4095];
  int            nAcc  = 0;
  int            mCnt  = 0;
  int            mLast = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sample_delay_line #(.DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inData(inData),
    .delaySel(delaySel), .outValid(outValid), .outData(outData)
  );

  task automatic report(input string tag, input bit ok, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and pushes the expected result.
  task automatic drive(input string tag, input bit v, input int d);
    int eff;
    logic [DW-1:0] smp;
    @(negedge clk);
    eff = (d == 0) ? 1 : d;
    smp = DW'(nAcc * 40503 + 7);
    inValid  = v;
    delaySel = 10'(d);
    inData   = v ? smp : 16'hDEAD;
    if (v) begin
      if (eff != mLast) mCnt = 0;
      expV.push_back(mCnt >= eff);
      expD.push_back((mCnt >= eff) ? hist[nAcc - eff] : '0);
      hist[nAcc] = smp;
      nAcc++;
      mCnt  = (mCnt + 1 > 1023) ? 1023 : mCnt + 1;
      mLast = eff;
    end else begin
      expV.push_back(1'b0);
      expD.push_back('0);
    end
    expTag.push_back(tag);
  endtask

  // Monitor: compares each output cycle against the scoreboard.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expV.size() > 0) begin
        logic          v;
        logic [DW-1:0] dd;
        string         t;
        v  = expV.pop_front();
        dd = expD.pop_front();
        t  = expTag.pop_front();
        report(t, outValid == v, int'(outValid), int'(v));
        if (v && outValid) report(t, outData == dd, int'(outData), int'(dd));
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    testsFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    report("R1 during reset", outValid == 1'b0, int'(outValid), 0);
    rst = 1'b0;
    @(negedge clk);
    report("R1 after release", outValid == 1'b0, int'(outValid), 0);

    // R2 and R3: fill then steady stream, delay 4, back to back.
    for (int i = 0; i < 20; i++) drive("R2/R3 delay4", 1'b1, 4);
    // R6: idle cycles interleaved.
    for (int i = 0; i < 12; i++) drive("R6 gaps", (i % 3) != 1, 4);
    // R4 with R7: delay 0 acts as 1 and restarts fill.
    for (int i = 0; i < 10; i++) drive("R4 delay0", 1'b1, 0);
    // R7: increase then decrease.
    for (int i = 0; i < 20; i++) drive("R7 up to 7", 1'b1, 7);
    for (int i = 0; i < 15; i++) drive("R7 down to 3", 1'b1, 3);
    drive("R6 idle", 1'b0, 3);
    drive("R7 same after idle", 1'b1, 3);
    // R5: maximum delay across pointer wrap.
    for (int i = 0; i < 1200; i++) drive("R5 delay1023", 1'b1, 1023);
    drive("R6 tail", 1'b0, 1023);
    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  end

endmodule